// File: doc/BRIEF.md
# Pulse Width Measurement Capture Timer

This block measures the time between successive qualifying transitions on one of two input pins. A 16-bit up-counter advances on a count enable. Each time a selected transition arrives on a pin, the counter's present value is copied into that pin's capture register, the counter restarts from zero, and a one-cycle interrupt pulse marks the event. Software reads a capture register after the pulse and gets the width of the interval that has just ended.

The block is configured through a small write port. A single write strobe loads the run bit, a three-bit mode field, one two-bit edge selector per pin and a clock-source select. The counter only runs in the measurement mode, code 110. It advances on either an internal per-cycle tick or on rising transitions of pin 0. When pin 0 supplies the clock, measurement is done on pin 1, and pin 0 can never cause a capture.

No interface of this block carries a data stream. Every pin is a plain level or single-cycle pulse with no handshake and no back-pressure. Software is expected to read a capture register before the next capture on that channel overwrites it.

Top module: `pwm_width_timer`

## Requirements
- R1: After reset both capture registers read 0000H and all three interrupt outputs are low.
- R2: The counter advances only while the registered run bit is 1 and the registered mode is 3'b110. Otherwise it is held at zero, and no capture or interrupt occurs.
- R3: Each pin has its own edge selector. 2'b00 detects nothing, 2'b01 detects rising transitions, 2'b10 detects falling transitions and 2'b11 detects both.
- R4: On a valid edge, the capture register of that pin receives the number of counter advances since the previous capture (or since the counter was last held at zero). The counter is cleared to zero in the same cycle.
- R5: Each capture raises that channel's interrupt for exactly one clock cycle. The new capture value and the pulse appear on the third rising clock edge after the pin changes (two synchronizer stages plus one edge stage).
- R6: With the internal source selected, each cycle with `cnt_tick` high advances the counter by one.
- R7: With the external source selected, each synchronized rising transition of pin 0 advances the counter. `cnt_tick` is ignored, and pin 0 never causes a capture, whatever its edge selector holds.
- R8: When an advance occurs at count FFFFH, the counter wraps to zero and `ovf_irq` pulses for one cycle.
- R9: When a capture and an overflow fall in the same cycle, the capture register gets FFFFH, the counter becomes zero and both interrupts pulse.
- R10: A capture register keeps its value until its next valid edge. Writing the run bit to 0 clears the counter but leaves both capture registers unchanged.
- R11: The configuration inputs take effect only in a cycle where `cfg_we` is high. Changing them without the strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads all configuration fields |
| cfg_run | input | 1 | Counter run bit |
| cfg_mode | input | 3 | Operating mode; 3'b110 selects measurement |
| cfg_edge0 | input | 2 | Edge selector for pin 0 |
| cfg_edge1 | input | 2 | Edge selector for pin 1 |
| cfg_ext_clk | input | 1 | 1: pin 0 rising transitions clock the counter |
| cnt_tick | input | 1 | Internal count enable, one advance per high cycle |
| cap_pin | input | 2 | Asynchronous measurement inputs, bit index = channel |
| cap0_data | output | 16 | Channel 0 capture register |
| cap1_data | output | 16 | Channel 1 capture register |
| cap0_irq | output | 1 | Channel 0 capture pulse |
| cap1_irq | output | 1 | Channel 1 capture pulse |
| ovf_irq | output | 1 | Counter wrap pulse |

## Verification
The bench tests the same-cycle capture and overflow case by placing a single tick exactly in the capture cycle at count FFFFH. A design that gave priority to the increment would store 0000H or leave the counter at 1, and one that dropped an interrupt would lose a pulse. Edge sequences cover every selector code and include transitions the selector must ignore, so an inverted or shared selector shows up as a spurious or missing capture and as a wrong accumulated count. Other tests check that pin 0 is ignored as a trigger in external-clock mode while it clocks the counter, and that clearing the run bit restarts the count without erasing the captures.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

  localparam logic [2:0] MODE_PULSE_MEAS = 3'b110;
  localparam int unsigned NUM_CH = 2;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic       run;
    logic [2:0] mode;
    edge_sel_e  edge0;
    edge_sel_e  edge1;
    logic       ext_clk;
  } cfg_t;

endpackage

// File: rtl/pwmc_pin_sync.sv
module pwmc_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [MSB:0] chain_q;
  logic         prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[MSB-1:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[MSB];
  end

  assign rise_o = chain_q[MSB] & ~prev_q;
  assign fall_o = ~chain_q[MSB] & prev_q;

endmodule

// File: rtl/pwmc_edge_qual.sv
module pwmc_edge_qual
  import pwmc_pkg::*;
(
  input  edge_sel_e sel_i,
  input  logic      rise_i,
  input  logic      fall_i,
  output logic      hit_o
);

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = rise_i;
      EDGE_FALL: hit_o = fall_i;
      EDGE_BOTH: hit_o = rise_i | fall_i;
      default:   hit_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwmc_counter.sv
module pwmc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             adv_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (!active_i || clear_i) cnt_q <= '0;
    else if (adv_i)                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = active_i & adv_i & (cnt_q == CNT_MAX);

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> cnt_q == '0);

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && clear_i) |=> cnt_q == '0);

  // R6
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && adv_i && !clear_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !adv_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwmc_capture.sv
module pwmc_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic [CNT_W-1:0] value_i,
  output logic [CNT_W-1:0] data_o,
  output logic             irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      irq_o <= fire_i;
      if (fire_i) data_o <= value_i;
    end
  end

  // R10
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_i |=> $stable(data_o));

  // R5
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> irq_o && data_o == $past(value_i));

endmodule

// File: rtl/pwm_width_timer.sv
module pwm_width_timer
  import pwmc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_run,
  input  logic [2:0]       cfg_mode,
  input  logic [1:0]       cfg_edge0,
  input  logic [1:0]       cfg_edge1,
  input  logic             cfg_ext_clk,
  input  logic             cnt_tick,
  input  logic [1:0]       cap_pin,
  output logic [CNT_W-1:0] cap0_data,
  output logic [CNT_W-1:0] cap1_data,
  output logic             cap0_irq,
  output logic             cap1_irq,
  output logic             ovf_irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{run: 1'b0, mode: 3'b000, edge0: EDGE_NONE,
                 edge1: EDGE_NONE, ext_clk: 1'b0};
    end else if (cfg_we) begin
      cfg_q.run     <= cfg_run;
      cfg_q.mode    <= cfg_mode;
      cfg_q.edge0   <= edge_sel_e'(cfg_edge0);
      cfg_q.edge1   <= edge_sel_e'(cfg_edge1);
      cfg_q.ext_clk <= cfg_ext_clk;
    end
  end

  logic active;
  assign active = cfg_q.run && (cfg_q.mode == MODE_PULSE_MEAS);

  edge_sel_e        sel_eff [NUM_CH];
  logic [NUM_CH-1:0] rise, fall, hit, fire;
  logic [CNT_W-1:0]  cap_data [NUM_CH];
  logic [NUM_CH-1:0] cap_irq;
  logic [CNT_W-1:0]  cnt;
  logic              ovf;
  logic              adv;

  // pin 0 cannot trigger while it is the count clock
  assign sel_eff[0] = cfg_q.ext_clk ? EDGE_NONE : cfg_q.edge0;
  assign sel_eff[1] = cfg_q.edge1;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      pwmc_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cap_pin[ch]),
        .rise_o (rise[ch]),
        .fall_o (fall[ch])
      );

      pwmc_edge_qual u_qual (
        .sel_i  (sel_eff[ch]),
        .rise_i (rise[ch]),
        .fall_i (fall[ch]),
        .hit_o  (hit[ch])
      );

      assign fire[ch] = active & hit[ch];

      pwmc_capture #(.CNT_W(CNT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire[ch]),
        .value_i (cnt),
        .data_o  (cap_data[ch]),
        .irq_o   (cap_irq[ch])
      );
    end
  endgenerate

  assign adv = cfg_q.ext_clk ? rise[0] : cnt_tick;

  pwmc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (active),
    .adv_i    (adv),
    .clear_i  (|fire),
    .cnt_o    (cnt),
    .ovf_o    (ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_irq <= 1'b0;
    else        ovf_irq <= ovf;
  end

  assign cap0_data = cap_data[0];
  assign cap1_data = cap_data[1];
  assign cap0_irq  = cap_irq[0];
  assign cap1_irq  = cap_irq[1];

  // R7
  ext_no_cap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.ext_clk |=> !cap0_irq);

  // R3
  none_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.edge1 == EDGE_NONE) |=> !cap1_irq);

  // R8
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> $past(cnt) == CNT_MAX);

  // R9
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && (|fire)) |=> ovf_irq && cnt == '0);

  // R2
  idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !cap0_irq && !cap1_irq && !ovf_irq);

endmodule

// File: tb/pwm_width_timer_test.sv
module pwm_width_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {edge1 selector, ticks before edge, new pin1 level, capture expected}
  localparam logic [11:0] VEC [NVEC] = '{
    {2'b01, 8'd5, 1'b1, 1'b1},
    {2'b01, 8'd3, 1'b0, 1'b0},
    {2'b01, 8'd4, 1'b1, 1'b1},
    {2'b10, 8'd2, 1'b0, 1'b1},
    {2'b10, 8'd6, 1'b1, 1'b0},
    {2'b11, 8'd1, 1'b0, 1'b1},
    {2'b11, 8'd9, 1'b1, 1'b1},
    {2'b00, 8'd3, 1'b0, 1'b0},
    {2'b00, 8'd2, 1'b1, 1'b0},
    {2'b10, 8'd0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_run = 1'b0, cfg_ext_clk = 1'b0, cnt_tick = 1'b0;
  logic [2:0]  cfg_mode = 3'b000;
  logic [1:0]  cfg_edge0 = 2'b00, cfg_edge1 = 2'b00;
  logic [1:0]  cap_pin = 2'b00;
  logic [15:0] cap0_data, cap1_data;
  logic        cap0_irq, cap1_irq, ovf_irq;

  int n_chk = 0, n_bad = 0;
  int n0 = 0, n1 = 0, nov = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_width_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_run(cfg_run),
    .cfg_mode(cfg_mode), .cfg_edge0(cfg_edge0), .cfg_edge1(cfg_edge1),
    .cfg_ext_clk(cfg_ext_clk), .cnt_tick(cnt_tick), .cap_pin(cap_pin),
    .cap0_data(cap0_data), .cap1_data(cap1_data),
    .cap0_irq(cap0_irq), .cap1_irq(cap1_irq), .ovf_irq(ovf_irq)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cap0_irq) n0++;
      if (cap1_irq) n1++;
      if (ovf_irq)  nov++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic run, input logic [2:0] mode,
                           input logic [1:0] e0, input logic [1:0] e1,
                           input logic ext);
    cfg_run = run; cfg_mode = mode; cfg_edge0 = e0; cfg_edge1 = e1;
    cfg_ext_clk = ext; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      cnt_tick = 1'b1;
      repeat (n) @(negedge clk);
      cnt_tick = 1'b0;
    end
  endtask

  task automatic pin_set(input int ch, input logic lvl);
    cap_pin[ch] = lvl;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int acc, last1, b0, b1, bo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 cap0", cap0_data, 0);
    check("R1 cap1", cap1_data, 0);
    check("R1 irqs", {cap0_irq, cap1_irq, ovf_irq}, 0);

    // R11: fields without strobe do nothing
    cfg_run = 1; cfg_mode = 3'b110; cfg_edge1 = 2'b01;
    ticks(5);
    pin_set(1, 1'b1);
    check("R11 no capture", n1, 0);
    check("R11 cap1", cap1_data, 0);
    pin_set(1, 1'b0);

    // R2: wrong mode keeps counter idle
    cfg_write(1, 3'b101, 2'b00, 2'b01, 0);
    ticks(4);
    pin_set(1, 1'b1);
    check("R2 no capture", n1, 0);
    check("R2 cap1", cap1_data, 0);
    pin_set(1, 1'b0);

    // R3 R4 R5 R6 vector walk
    cfg_write(1, 3'b110, 2'b00, 2'b01, 0);
    acc = 0; last1 = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] esel;
      int nt;
      logic lvl, fires;
      {esel, nt, lvl, fires} = {VEC[i][11:10], 24'd0, VEC[i][9:2], VEC[i][1], VEC[i][0]};
      cfg_write(1, 3'b110, 2'b00, esel, 0);
      b1 = n1;
      ticks(nt);
      acc += nt;
      pin_set(1, lvl);
      if (fires) begin last1 = acc; acc = 0; end
      check($sformatf("R3 vec%0d pulse count", i), n1 - b1, fires ? 1 : 0);
      check($sformatf("R4 vec%0d cap1", i), cap1_data, last1);
    end

    // R5: channel 0 capture, one pulse, channel 1 untouched
    cfg_write(1, 3'b110, 2'b01, 2'b00, 0);
    b0 = n0; b1 = n1;
    ticks(6);
    pin_set(0, 1'b1);
    check("R5 cap0", cap0_data, 6);
    check("R5 cap0 pulses", n0 - b0, 1);
    check("R5 cap1 pulses", n1 - b1, 0);
    check("R10 cap1 held", cap1_data, last1);
    pin_set(0, 1'b0);

    // R10: run cleared resets counter, keeps captures
    cfg_write(1, 3'b110, 2'b00, 2'b01, 0);
    ticks(5);
    cfg_write(0, 3'b110, 2'b00, 2'b01, 0);
    check("R10 cap0 kept", cap0_data, 6);
    check("R10 cap1 kept", cap1_data, last1);
    cfg_write(1, 3'b110, 2'b00, 2'b01, 0);
    ticks(2);
    pin_set(1, 1'b1);
    check("R10 restart", cap1_data, 2);
    pin_set(1, 1'b0);

    // R7: pin 0 clocks, tick ignored, pin 0 never captures
    cfg_write(1, 3'b110, 2'b11, 2'b01, 1);
    b0 = n0;
    cnt_tick = 1'b1;
    for (int k = 0; k < 7; k++) begin
      pin_set(0, 1'b1);
      pin_set(0, 1'b0);
    end
    pin_set(1, 1'b1);
    cnt_tick = 1'b0;
    check("R7 ext count", cap1_data, 7);
    check("R7 no cap0", n0 - b0, 0);
    check("R7 cap0 kept", cap0_data, 6);
    pin_set(1, 1'b0);
    cfg_write(1, 3'b110, 2'b00, 2'b01, 0);

    // R8: wrap
    bo = nov;
    ticks(65536);
    @(negedge clk);
    check("R8 ovf pulse", nov - bo, 1);
    ticks(3);
    pin_set(1, 1'b1);
    check("R8 wrapped count", cap1_data, 3);
    pin_set(1, 1'b0);

    // R9: capture and overflow in the same cycle
    bo = nov; b1 = n1;
    ticks(65535);
    check("R9 no early ovf", nov - bo, 0);
    cap_pin[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 cap1", cap1_data, 16'hFFFF);
    check("R9 ovf pulse", nov - bo, 1);
    check("R9 cap pulse", n1 - b1, 1);
    pin_set(1, 1'b0);
    ticks(4);
    pin_set(1, 1'b1);
    check("R9 counter cleared", cap1_data, 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule